// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a single-channel transmit DMA engine. Software places 16-byte descriptors in a ring in memory, each naming a packet buffer and its length. It then tells the engine how far the ring is filled by writing a producer index. The engine takes the descriptors in ring order and reads each one's buffer through a word-wide memory port. It sends the packet out one byte at a time on a valid/ready stream. When a packet is done, it writes the control word back with the hardware-ownership flag cleared, so the descriptor belongs to software again, and it raises an interrupt flag.

A small register port holds the ring base address, the ring size, the producer index, a stop control, a packed progress word and a write-one-to-clear interrupt flag. The progress word reports two indices. One is the index of the descriptor the engine has returned to software. The other is the index up to which the engine counts descriptors as submitted, and that count never runs more than four ahead of the returned index.

Register byte offsets on `reg_addr`:

| Offset | Register | Access | Meaning |
|---|---|---|---|
| 0x00 | BASE | read/write | byte address of descriptor 0 |
| 0x04 | SIZE | read/write | bits 3:0 hold log2 of the ring size |
| 0x08 | PRODUCER | read/write | producer index |
| 0x0C | PROGRESS | read only | bits 31:16 visible submitted index, bits 15:0 returned index |
| 0x10 | HALT | read/write | bit 0 halts the engine |
| 0x14 | EVENT | write one to clear | bit 0 is the interrupt flag |

Top module: `txring_engine`

## Requirements
- R1: After reset, PROGRESS (0x0C) reads 0, HALT (0x10) bit 0 reads 1, EVENT (0x14) bit 0 and `irq` are 0, and `mem_req` and `tx_valid` are low.
- R2: While HALT bit 0 is 1, the engine issues no memory request even when descriptors are pending. Writing 0 to HALT bit 0 starts processing.
- R3: The descriptor with ring index k sits at byte address BASE + 16*k. Its control word is at offset 0 and its buffer byte address is at offset 4. The ring has 2^SIZE entries, and every index wraps modulo that size. A SIZE write of 0 is taken as 1, and a SIZE write above MAX_LOG2 is taken as MAX_LOG2.
- R4: Descriptor k is pending while the returned index differs from PRODUCER (0x08). The engine streams control bits 13:0 bytes from the buffer in ascending byte-address order, taking byte lane a mod 4 of the 32-bit word at a - (a mod 4). The buffer may start at any byte alignment. `tx_last` is high only with the final byte.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: If the fetched control word has bit 15 (hardware owns) clear, no byte is streamed and the returned index does not move. The engine polls the descriptor again until bit 15 is set.
- R7: After the final byte is accepted, the engine writes the control word back to the descriptor's address with bit 15 cleared and every other bit unchanged. The returned index then advances by one, and EVENT bit 0 and `irq` become 1.
- R8: An owned descriptor whose length field is 0 is written back and returned at once, with no byte streamed.
- R9: PROGRESS bits 15:0 give the returned index r. Bits 31:16 give (r + min(p, 4)) mod size, where p = (PRODUCER - r) mod size.
- R10: Writing 1 to EVENT bit 0 clears it and `irq`. Writing 0 leaves it unchanged.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 5 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address, word aligned |
| mem_wdata | output | 32 | memory write data |
| mem_ack | input | 1 | access done; read data valid this cycle |
| mem_rdata | input | 32 | memory read data |
| tx_valid | output | 1 | stream byte valid |
| tx_ready | input | 1 | stream sink ready |
| tx_data | output | 8 | stream byte |
| tx_last | output | 1 | final byte of the packet |
| irq | output | 1 | interrupt, copy of EVENT bit 0 |

## Verification
A wrong returned index has two visible effects. PROGRESS shows it in the cycle after the faulty update. The next descriptor fetch also goes to the wrong address, so the writeback lands somewhere else and the packet's bytes come from the wrong buffer. A byte-address counter that is off by one shows up on the very next accepted byte as a wrong lane or a wrong word. A length or last-byte error shows as a wrong byte count or a misplaced `tx_last` in the same packet. Errors in the ownership or halt logic show as stream traffic or memory requests within a few cycles of the stimulus.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 16;
  localparam int LEN_W  = 14;
  localparam int OWN_BIT = 15;
  localparam int DESC_SHIFT = 4;

  localparam logic [4:0] OFS_BASE = 5'h00;
  localparam logic [4:0] OFS_SIZE = 5'h04;
  localparam logic [4:0] OFS_PROD = 5'h08;
  localparam logic [4:0] OFS_PROG = 5'h0C;
  localparam logic [4:0] OFS_HALT = 5'h10;
  localparam logic [4:0] OFS_EVT  = 5'h14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_BUF, ST_WORD, ST_SEND, ST_WB
  } txr_state_e;

  function automatic logic [IDX_W-1:0] ring_mask(input logic [3:0] lg);
    return IDX_W'((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [IDX_W-1:0] vis_idx(input logic [IDX_W-1:0] ret,
                                               input logic [IDX_W-1:0] prod,
                                               input logic [IDX_W-1:0] mask,
                                               input int cap);
    logic [IDX_W-1:0] pend;
    logic [IDX_W-1:0] take;
    pend = (prod - ret) & mask;
    take = (pend > IDX_W'(cap)) ? IDX_W'(cap) : pend;
    return (ret + take) & mask;
  endfunction

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << DESC_SHIFT);
  endfunction

endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int VIS_CAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ret_adv,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  ret_idx,
  output logic              pending,
  output logic              halt,
  output logic              irq
);

  logic [ADDR_W-1:0] base_q;
  logic [3:0]        size_q;
  logic [IDX_W-1:0]  prod_q;
  logic [IDX_W-1:0]  ret_q;
  logic              halt_q;
  logic              evt_q;
  logic [IDX_W-1:0]  mask;
  logic [IDX_W-1:0]  vis;
  logic [3:0]        size_wr;

  assign mask = ring_mask(size_q);
  assign vis  = vis_idx(ret_q, prod_q, mask, VIS_CAP);

  always_comb begin
    size_wr = reg_wdata[3:0];
    if (size_wr == 4'd0) size_wr = 4'd1;
    else if (size_wr > 4'(MAX_LOG2)) size_wr = 4'(MAX_LOG2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= 4'd2;
      prod_q <= '0;
      ret_q  <= '0;
      halt_q <= 1'b1;
      evt_q  <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          OFS_BASE: base_q <= reg_wdata;
          OFS_SIZE: size_q <= size_wr;
          OFS_PROD: prod_q <= reg_wdata[IDX_W-1:0] & mask;
          OFS_HALT: halt_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (ret_adv) ret_q <= (ret_q + 1'b1) & mask;
      if (ret_adv) evt_q <= 1'b1;
      else if (reg_we && reg_addr == OFS_EVT && reg_wdata[0]) evt_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE: reg_rdata = base_q;
      OFS_SIZE: reg_rdata = {28'd0, size_q};
      OFS_PROD: reg_rdata = 32'(prod_q);
      OFS_PROG: reg_rdata = {vis, ret_q};
      OFS_HALT: reg_rdata = {31'd0, halt_q};
      OFS_EVT:  reg_rdata = {31'd0, evt_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign base    = base_q;
  assign ret_idx = ret_q;
  assign pending = (prod_q != ret_q);
  assign halt    = halt_q;
  assign irq     = evt_q;

  // A return always raises the event flag on the next cycle.
  assert_evt_on_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_adv |=> irq);

  // The returned index moves only when a descriptor is handed back.
  assert_ret_only_on_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_adv |=> $stable(ret_q));

endmodule

// File: rtl/txr_lane.sv
module txr_lane
  import txr_pkg::*;
#(
  parameter int NB = DATA_W / 8
) (
  input  logic [8*NB-1:0]        word,
  input  logic [$clog2(NB)-1:0]  lane,
  input  logic [LEN_W-1:0]       remain,
  output logic [7:0]             byte_out,
  output logic                   last
);

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_out = lanes[lane];
  assign last     = (remain == LEN_W'(1));

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              pending,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ret_adv,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);

  localparam int LANE_W = $clog2(NB);

  txr_state_e        st;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] word_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  remain_q;
  logic [ADDR_W-1:0] dsc;
  logic              beat;
  logic              lane_end;

  assign dsc      = desc_addr(base, ret_idx);
  assign beat     = tx_valid && tx_ready;
  assign lane_end = (cur_q[LANE_W-1:0] == LANE_W'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ctl_q    <= '0;
      word_q   <= '0;
      cur_q    <= '0;
      remain_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (!halt && pending) st <= ST_CTL;
        ST_CTL: if (mem_ack) begin
          ctl_q <= mem_rdata;
          if (!mem_rdata[OWN_BIT])                  st <= ST_IDLE;
          else if (mem_rdata[LEN_W-1:0] == '0)      st <= ST_WB;
          else                                      st <= ST_BUF;
        end
        ST_BUF: if (mem_ack) begin
          cur_q    <= ADDR_W'(mem_rdata);
          remain_q <= ctl_q[LEN_W-1:0];
          st       <= ST_WORD;
        end
        ST_WORD: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= ST_SEND;
        end
        ST_SEND: if (beat) begin
          cur_q    <= cur_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) st <= ST_WB;
          else if (lane_end)         st <= ST_WORD;
        end
        ST_WB: if (mem_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req = (st == ST_CTL) || (st == ST_BUF) || (st == ST_WORD) || (st == ST_WB);
    mem_we  = (st == ST_WB);
    case (st)
      ST_BUF:  mem_addr = dsc + ADDR_W'(4);
      ST_WORD: mem_addr = {cur_q[ADDR_W-1:LANE_W], LANE_W'(0)};
      default: mem_addr = dsc;
    endcase
  end

  assign mem_wdata = ctl_q & ~(DATA_W'(1) << OWN_BIT);
  assign ret_adv   = (st == ST_WB) && mem_ack;
  assign tx_valid  = (st == ST_SEND);

  txr_lane #(.NB(NB)) u_lane (
    .word     (word_q),
    .lane     (cur_q[LANE_W-1:0]),
    .remain   (remain_q),
    .byte_out (tx_data),
    .last     (tx_last)
  );

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && halt |=> !mem_req);

  assert_last_then_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat && tx_last |=> mem_req && mem_we);

  assert_wb_owner_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int VIS_CAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq
);

  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  ret_idx;
  logic              pending;
  logic              halt;
  logic              ret_adv;

  txr_regs #(.MAX_LOG2(MAX_LOG2), .VIS_CAP(VIS_CAP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ret_adv   (ret_adv),
    .base      (base),
    .ret_idx   (ret_idx),
    .pending   (pending),
    .halt      (halt),
    .irq       (irq)
  );

  txr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .pending   (pending),
    .base      (base),
    .ret_idx   (ret_idx),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .ret_adv   (ret_adv),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last)
  );

endmodule

// File: tb/tb_txring_engine.sv
module tb_txring_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [31:0] DBASE = 32'h40;

  // vector: {length[13:0], buffer byte address[9:0], ready pattern[1:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {14'd1,  10'h100, 2'd0},
    {14'd7,  10'h105, 2'd1},
    {14'd4,  10'h120, 2'd0},
    {14'd13, 10'h143, 2'd2},
    {14'd9,  10'h202, 2'd1},
    {14'd32, 10'h301, 2'd2}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_data_unused;
  logic [7:0] tx_data;
  logic tx_last, irq;

  txring_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  function automatic logic [7:0] pat_byte(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // bench memory: 256 words, one-cycle acknowledge
  logic [31:0] mem [256];
  logic ack_q = 0;
  logic [31:0] rdata_q = 0;
  logic tb_wr = 0;
  logic [7:0] tb_wr_idx = 0;
  logic [31:0] tb_wr_val = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++)
        mem[k] <= {pat_byte(4*k+3), pat_byte(4*k+2), pat_byte(4*k+1), pat_byte(4*k)};
      ack_q <= 0;
    end else begin
      ack_q <= mem_req && !ack_q;
      rdata_q <= mem[mem_addr[9:2]];
      if (mem_req && mem_we && !ack_q) mem[mem_addr[9:2]] <= mem_wdata;
      if (tb_wr) mem[tb_wr_idx] <= tb_wr_val;
    end
  end
  assign mem_ack = ack_q;
  assign mem_rdata = rdata_q;
  assign tx_data_unused = 1'b0;

  // stream sink with selectable back-pressure
  int rmode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : ((cyc % 3) == 0);
  end

  // monitors
  logic [7:0] got [1024];
  int got_n = 0, last_n = 0, last_at = -1;
  int wb_n = 0, req_n = 0;
  logic [31:0] wb_addr = 0, wb_data = 0;
  int hold_bad = 0, memhold_bad = 0;
  logic hold_prev = 0, memhold_prev = 0;
  logic [7:0] prev_data = 0;
  logic prev_last = 0;
  logic [31:0] prev_maddr = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        got[got_n % 1024] <= tx_data;
        if (tx_last) begin last_n <= last_n + 1; last_at <= got_n; end
        got_n <= got_n + 1;
      end
      if (mem_req) req_n <= req_n + 1;
      if (mem_req && mem_we && mem_ack) begin
        wb_n <= wb_n + 1; wb_addr <= mem_addr; wb_data <= mem_wdata;
      end
      if (hold_prev && (!tx_valid || tx_data != prev_data || tx_last != prev_last))
        hold_bad <= hold_bad + 1;
      if (memhold_prev && (!mem_req || mem_addr != prev_maddr))
        memhold_bad <= memhold_bad + 1;
      hold_prev <= tx_valid && !tx_ready;
      prev_data <= tx_data;
      prev_last <= tx_last;
      memhold_prev <= mem_req && !mem_ack;
      prev_maddr <= mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_wr = 1; tb_wr_idx = a[9:2]; tb_wr_val = d;
    @(negedge clk); tb_wr = 0;
  endtask

  task automatic wait_irq(input int maxc, output bit ok);
    ok = 0;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] rv;
    bit ok;
    int g0, l0, w0, len, bufa, idx, bad, r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    reg_read(5'h0C, rv); check(rv == 0, "R1 progress", rv, 0);
    reg_read(5'h10, rv); check(rv == 1, "R1 halt", rv, 1);
    reg_read(5'h14, rv); check(rv == 0, "R1 event", rv, 0);
    check(irq == 0 && tx_valid == 0, "R1 irq/tx_valid", {irq, tx_valid}, 0);
    check(mem_req == 0, "R1 mem_req", mem_req, 0);

    reg_write(5'h00, DBASE);
    reg_write(5'h04, 2);

    for (int i = 0; i < NVEC; i++) begin
      len  = int'(VEC[i][25:12]);
      bufa = int'(VEC[i][11:2]);
      rmode = int'(VEC[i][1:0]);
      idx = i % 4;
      poke(DBASE + 16*idx, 32'hC000 | len);
      poke(DBASE + 16*idx + 4, bufa);
      g0 = got_n; l0 = last_n; w0 = wb_n;
      reg_write(5'h08, (i + 1) % 4);
      if (i == 0) begin
        repeat (30) @(negedge clk);
        check(req_n == 0, "R2 halted no request", req_n, 0);
        reg_read(5'h0C, rv); check(rv[15:0] == 0, "R2 halted no return", rv, 0);
        reg_write(5'h10, 0);
      end
      wait_irq(3000, ok);
      check(ok, "R7 irq after packet", ok, 1);
      check(got_n - g0 == len, "R4 byte count", got_n - g0, len);
      bad = 0;
      for (int b = 0; b < len; b++)
        if (got[(g0 + b) % 1024] != pat_byte(bufa + b)) bad++;
      check(bad == 0, "R4 byte order and values", bad, 0);
      check(last_n - l0 == 1 && last_at == got_n - 1, "R4 last on final byte", last_at, got_n - 1);
      check(wb_n - w0 == 1 && wb_addr == DBASE + 16*idx, "R3 writeback address", wb_addr, DBASE + 16*idx);
      check(wb_data == (32'h4000 | len), "R7 writeback word", wb_data, 32'h4000 | len);
      r = (i + 1) % 4;
      reg_read(5'h0C, rv);
      check(rv == {16'(r), 16'(r)}, "R3 R9 progress after return", rv, {16'(r), 16'(r)});
      reg_write(5'h14, 1);
    end

    // R9: visible submitted index capped at four ahead
    reg_write(5'h10, 1);
    reg_write(5'h04, 3);
    reg_write(5'h08, 1);
    reg_read(5'h0C, rv); check(rv == 32'h00060002, "R9 cap at four", rv, 32'h00060002);
    reg_write(5'h08, 4);
    reg_read(5'h0C, rv); check(rv == 32'h00040002, "R9 below cap", rv, 32'h00040002);

    // R6: descriptor not owned by hardware
    poke(DBASE + 16*2, 32'h4005);
    poke(DBASE + 16*2 + 4, 32'h110);
    reg_write(5'h08, 3);
    g0 = got_n;
    reg_write(5'h10, 0);
    repeat (40) @(negedge clk);
    check(got_n == g0, "R6 no bytes while not owned", got_n - g0, 0);
    reg_read(5'h0C, rv); check(rv[15:0] == 2 && irq == 0, "R6 no return while not owned", rv, 32'h00030002);
    poke(DBASE + 16*2, 32'hC005);
    wait_irq(3000, ok);
    check(ok && got_n - g0 == 5, "R6 resumes once owned", got_n - g0, 5);
    reg_read(5'h0C, rv); check(rv[15:0] == 3, "R6 returned after resume", rv[15:0], 3);
    reg_write(5'h14, 1);

    // R8: zero-length descriptor
    poke(DBASE + 16*3, 32'hC000);
    poke(DBASE + 16*3 + 4, 32'h200);
    g0 = got_n;
    reg_write(5'h08, 4);
    wait_irq(3000, ok);
    check(ok && got_n == g0, "R8 zero length no bytes", got_n - g0, 0);
    check(wb_data == 32'h4000 && wb_addr == DBASE + 48, "R8 zero length writeback", wb_data, 32'h4000);
    reg_read(5'h0C, rv); check(rv == 32'h00040004, "R8 returned", rv, 32'h00040004);

    // R10: write-one-to-clear event flag
    reg_write(5'h14, 0);
    check(irq == 1, "R10 write zero keeps flag", irq, 1);
    reg_write(5'h14, 1);
    check(irq == 0, "R10 write one clears flag", irq, 0);

    check(hold_bad == 0, "R5 stream held under back-pressure", hold_bad, 0);
    check(memhold_bad == 0, "R11 request held until ack", memhold_bad, 0);

    summary();
  end

endmodule